// File: doc/BRIEF.md
# Deblocking Edge Decision Unit

This block decides, for one column of pixels that crosses a block edge, how strongly a high-bit-depth deblocking filter is to smooth that edge. It receives eight samples on each side of the edge, together with three 8-bit strength thresholds and a select between 10-bit and 12-bit video. It returns one filter-width choice: wide (sixteen taps), medium (eight taps), narrow (four taps) or none. It also returns a flag that marks high activity next to the edge. The filtering itself is left to a downstream stage that consumes these decisions.

The thresholds are compared against sample differences after being rescaled to the pixel depth. A flatness limit is derived from the depth alone. Three tests feed the final choice: a filter-enable test on the neighbour steps and on the step across the edge, an inner flatness test over three samples on each side, and an outer flatness test over the remaining four samples on each side. A parameter caps the widest filter that the surrounding filter supports.

Each result is captured in a single output register. That register is managed by a two-state stage controller with a valid/ready handshake, so a stalled consumer holds the result and stops new input.

Top module: `dbk_edge_decide`

## Requirements
- R1: With `depth_hi`=0 (10-bit), the thresholds `thr_e`, `thr_i` and `thr_h` are each multiplied by 4 and the flatness limit F is 4. With `depth_hi`=1 (12-bit), the multiplier is 16 and F is 16.
- R2: With `depth_hi`=0, bits 11:10 of every sample are ignored and the sample is taken as its low 10 bits.
- R3: The filter enable fm is true only when two conditions hold. First, each of |p3-p2|, |p2-p1|, |p1-p0|, |q1-q0|, |q2-q1| and |q3-q2| is at most the scaled I. Second, 2·|q0-p0| + (|q1-p1| >> 1) is at most the scaled E. `dec_none` equals !fm.
- R4: `dec_hev` is true when |p1-p0| or |q1-q0| exceeds the scaled H.
- R5: Inner flatness is true when |pk-p0| and |qk-q0| are at most F for k = 1, 2 and 3.
- R6: Outer flatness is true when |pk-p0| and |qk-q0| are at most F for k = 4 to 7.
- R7: `dec_f16` = fm & inner & outer, `dec_f8` = fm & inner & !outer, and `dec_f4` = fm & !inner. While `out_valid` is 1, exactly one of `dec_f16`, `dec_f8`, `dec_f4` and `dec_none` is 1.
- R8: With WIDTH_MODE=8, outer flatness is treated as false. With WIDTH_MODE=4, inner flatness is also treated as false, so every enabled edge gets `dec_f4`.
- R9: After reset, `out_valid`=0 and `in_ready`=1. An input accepted (in_valid & in_ready) at one clock edge appears on the outputs with `out_valid`=1 after that edge.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and the outputs hold their values.
- R11: When `out_valid`=1, `out_ready`=1 and `in_valid`=0 at a clock edge, `out_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample set is valid |
| in_ready | output | 1 | Block can accept an input this cycle |
| p_taps | input | 96 | Samples before the edge, pk at bits [12k+11:12k], p0 nearest the edge |
| q_taps | input | 96 | Samples after the edge, qk at bits [12k+11:12k], q0 nearest the edge |
| thr_e | input | 8 | Edge-step threshold, before scaling |
| thr_i | input | 8 | Neighbour-step threshold, before scaling |
| thr_h | input | 8 | Activity threshold, before scaling |
| depth_hi | input | 1 | 0 = 10-bit samples, 1 = 12-bit samples |
| out_valid | output | 1 | Registered decision is valid |
| out_ready | input | 1 | Consumer takes the decision this cycle |
| dec_f16 | output | 1 | Apply the wide filter |
| dec_f8 | output | 1 | Apply the medium filter |
| dec_f4 | output | 1 | Apply the narrow filter |
| dec_none | output | 1 | Leave the edge untouched |
| dec_hev | output | 1 | High activity beside the edge |

## Verification
The bench builds three copies of the block side by side, with WIDTH_MODE set to 16, 8 and 4, and gives them the same inputs. Every vector therefore checks the width capping of R8 against the uncapped result. Both bit depths are swept. Single-tap steps are set exactly at the limit and one above it for every tap, for the I, E and H thresholds and for the flatness limit, which puts every comparison boundary within reach. Pseudo-random columns with high bits set in 10-bit mode cover mixed cases, and a scripted stall sequence covers the stage controller's transitions.

// File: rtl/dbk_pkg.sv
package dbk_pkg;

    // Output stage controller states
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_t;

    // One registered decision
    typedef struct packed {
        logic f16;
        logic f8;
        logic f4;
        logic none;
        logic hev;
    } edge_dec_t;

endpackage

// File: rtl/dbk_thresh_scale.sv
module dbk_thresh_scale #(
    parameter int THR_W    = 8,
    parameter int SHIFT_LO = 2,
    parameter int SHIFT_HI = 4,
    parameter int OUT_W    = THR_W + SHIFT_HI
) (
    input  logic             hi_depth,
    input  logic [THR_W-1:0] e_raw,
    input  logic [THR_W-1:0] i_raw,
    input  logic [THR_W-1:0] h_raw,
    output logic [OUT_W-1:0] e_scl,
    output logic [OUT_W-1:0] i_scl,
    output logic [OUT_W-1:0] h_scl,
    output logic [OUT_W-1:0] f_scl
);

    always_comb begin
        if (hi_depth) begin
            e_scl = OUT_W'(e_raw) << SHIFT_HI;
            i_scl = OUT_W'(i_raw) << SHIFT_HI;
            h_scl = OUT_W'(h_raw) << SHIFT_HI;
            f_scl = OUT_W'(1)     << SHIFT_HI;
        end else begin
            e_scl = OUT_W'(e_raw) << SHIFT_LO;
            i_scl = OUT_W'(i_raw) << SHIFT_LO;
            h_scl = OUT_W'(h_raw) << SHIFT_LO;
            f_scl = OUT_W'(1)     << SHIFT_LO;
        end
    end

endmodule

// File: rtl/dbk_side_metrics.sv
module dbk_side_metrics #(
    parameter int SAMPLE_W = 12,
    parameter int TAPS     = 8,
    parameter int THR_SW   = 12
) (
    input  logic [TAPS*SAMPLE_W-1:0] taps,
    input  logic [THR_SW-1:0]        thr_i,
    input  logic [THR_SW-1:0]        thr_h,
    input  logic [THR_SW-1:0]        thr_f,
    output logic                     nbr_ok,
    output logic                     flat_in,
    output logic                     flat_out,
    output logic                     act_hi
);

    localparam int CMP_W = (SAMPLE_W > THR_SW) ? SAMPLE_W : THR_SW;
    localparam int INNER = 4;

    function automatic logic [SAMPLE_W-1:0] absdiff(input logic [SAMPLE_W-1:0] a,
                                                    input logic [SAMPLE_W-1:0] b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    logic [SAMPLE_W-1:0] tap [TAPS];
    logic [TAPS-1:0]     near_ok;
    logic [INNER-1:0]    step_ok;

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_tap
            assign tap[k] = taps[k*SAMPLE_W +: SAMPLE_W];
            if (k == 0) begin : g_ref
                assign near_ok[k] = 1'b1;
            end else begin : g_cmp
                assign near_ok[k] = CMP_W'(absdiff(tap[k], tap[0])) <= CMP_W'(thr_f);
            end
        end
        for (genvar k = 0; k < INNER; k++) begin : g_step
            if (k == 0) begin : g_ref
                assign step_ok[k] = 1'b1;
            end else begin : g_cmp
                assign step_ok[k] = CMP_W'(absdiff(tap[k], tap[k-1])) <= CMP_W'(thr_i);
            end
        end
    endgenerate

    assign nbr_ok   = &step_ok;
    assign flat_in  = &near_ok[INNER-1:0];
    assign flat_out = &near_ok[TAPS-1:INNER];
    assign act_hi   = CMP_W'(absdiff(tap[1], tap[0])) > CMP_W'(thr_h);

endmodule

// File: rtl/dbk_decide.sv
module dbk_decide import dbk_pkg::*; #(
    parameter int SAMPLE_W   = 12,
    parameter int THR_SW     = 12,
    parameter int WIDTH_MODE = 16
) (
    input  logic [SAMPLE_W-1:0] p0,
    input  logic [SAMPLE_W-1:0] p1,
    input  logic [SAMPLE_W-1:0] q0,
    input  logic [SAMPLE_W-1:0] q1,
    input  logic [THR_SW-1:0]   thr_e,
    input  logic                p_nbr_ok,
    input  logic                q_nbr_ok,
    input  logic                p_flat_in,
    input  logic                q_flat_in,
    input  logic                p_flat_out,
    input  logic                q_flat_out,
    input  logic                p_act,
    input  logic                q_act,
    output edge_dec_t           dec
);

    localparam int MW = ((SAMPLE_W + 2) > THR_SW) ? (SAMPLE_W + 2) : THR_SW;

    logic [SAMPLE_W-1:0] ad0, ad1;
    logic [MW-1:0]       metric;
    logic                fm, use_in, use_out;

    assign ad0    = (q0 > p0) ? (q0 - p0) : (p0 - q0);
    assign ad1    = (q1 > p1) ? (q1 - p1) : (p1 - q1);
    assign metric = (MW'(ad0) << 1) + MW'(ad1 >> 1);
    assign fm     = p_nbr_ok & q_nbr_ok & (metric <= MW'(thr_e));

    generate
        if (WIDTH_MODE >= 16) begin : g_out_on
            assign use_out = p_flat_out & q_flat_out;
        end else begin : g_out_off
            assign use_out = 1'b0;
        end
        if (WIDTH_MODE >= 8) begin : g_in_on
            assign use_in = p_flat_in & q_flat_in;
        end else begin : g_in_off
            assign use_in = 1'b0;
        end
    endgenerate

    always_comb begin
        dec.f16  = fm & use_in & use_out;
        dec.f8   = fm & use_in & ~use_out;
        dec.f4   = fm & ~use_in;
        dec.none = ~fm;
        dec.hev  = p_act | q_act;
    end

endmodule

// File: rtl/dbk_edge_decide.sv
module dbk_edge_decide import dbk_pkg::*; #(
    parameter int SAMPLE_W   = 12,
    parameter int THR_W      = 8,
    parameter int TAPS       = 8,
    parameter int WIDTH_MODE = 16,
    parameter int SHIFT_LO   = 2,
    parameter int SHIFT_HI   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic [TAPS*SAMPLE_W-1:0] p_taps,
    input  logic [TAPS*SAMPLE_W-1:0] q_taps,
    input  logic [THR_W-1:0]         thr_e,
    input  logic [THR_W-1:0]         thr_i,
    input  logic [THR_W-1:0]         thr_h,
    input  logic                     depth_hi,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic                     dec_f16,
    output logic                     dec_f8,
    output logic                     dec_f4,
    output logic                     dec_none,
    output logic                     dec_hev
);

    localparam int THR_SW = THR_W + SHIFT_HI;
    localparam int LOW_W  = SAMPLE_W - (SHIFT_HI - SHIFT_LO);
    localparam logic [SAMPLE_W-1:0] LOW_MASK = {{(SAMPLE_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};

    // Depth masking of the samples
    logic [TAPS*SAMPLE_W-1:0] p_m, q_m;

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_mask
            assign p_m[k*SAMPLE_W +: SAMPLE_W] = depth_hi ? p_taps[k*SAMPLE_W +: SAMPLE_W]
                                                          : (p_taps[k*SAMPLE_W +: SAMPLE_W] & LOW_MASK);
            assign q_m[k*SAMPLE_W +: SAMPLE_W] = depth_hi ? q_taps[k*SAMPLE_W +: SAMPLE_W]
                                                          : (q_taps[k*SAMPLE_W +: SAMPLE_W] & LOW_MASK);
        end
    endgenerate

    // Threshold scaling
    logic [THR_SW-1:0] e_s, i_s, h_s, f_s;

    dbk_thresh_scale #(
        .THR_W   (THR_W),
        .SHIFT_LO(SHIFT_LO),
        .SHIFT_HI(SHIFT_HI),
        .OUT_W   (THR_SW)
    ) u_scale (
        .hi_depth(depth_hi),
        .e_raw   (thr_e),
        .i_raw   (thr_i),
        .h_raw   (thr_h),
        .e_scl   (e_s),
        .i_scl   (i_s),
        .h_scl   (h_s),
        .f_scl   (f_s)
    );

    // Per-side tests
    logic p_nbr, q_nbr, p_fin, q_fin, p_fout, q_fout, p_act, q_act;

    dbk_side_metrics #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS), .THR_SW(THR_SW)) u_side_p (
        .taps(p_m), .thr_i(i_s), .thr_h(h_s), .thr_f(f_s),
        .nbr_ok(p_nbr), .flat_in(p_fin), .flat_out(p_fout), .act_hi(p_act)
    );

    dbk_side_metrics #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS), .THR_SW(THR_SW)) u_side_q (
        .taps(q_m), .thr_i(i_s), .thr_h(h_s), .thr_f(f_s),
        .nbr_ok(q_nbr), .flat_in(q_fin), .flat_out(q_fout), .act_hi(q_act)
    );

    // Decision combine
    edge_dec_t dec_d, dec_q;

    dbk_decide #(.SAMPLE_W(SAMPLE_W), .THR_SW(THR_SW), .WIDTH_MODE(WIDTH_MODE)) u_decide (
        .p0(p_m[0 +: SAMPLE_W]),
        .p1(p_m[SAMPLE_W +: SAMPLE_W]),
        .q0(q_m[0 +: SAMPLE_W]),
        .q1(q_m[SAMPLE_W +: SAMPLE_W]),
        .thr_e(e_s),
        .p_nbr_ok(p_nbr), .q_nbr_ok(q_nbr),
        .p_flat_in(p_fin), .q_flat_in(q_fin),
        .p_flat_out(p_fout), .q_flat_out(q_fout),
        .p_act(p_act), .q_act(q_act),
        .dec(dec_d)
    );

    // Output stage controller
    stage_state_t state_q, state_d;
    logic         accept;

    assign accept = in_valid & in_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid)               state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        in_ready  = (state_q == ST_EMPTY) || out_ready;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dec_q <= '0;
        else if (accept) dec_q <= dec_d;
    end

    assign dec_f16  = dec_q.f16;
    assign dec_f8   = dec_q.f8;
    assign dec_f4   = dec_q.f4;
    assign dec_none = dec_q.none;
    assign dec_hev  = dec_q.hev;

endmodule

// File: rtl/dbk_edge_decide_chk.sv
module dbk_edge_decide_chk #(
    parameter int WIDTH_MODE = 16
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic out_valid,
    input logic out_ready,
    input logic dec_f16,
    input logic dec_f8,
    input logic dec_f4,
    input logic dec_none,
    input logic dec_hev
);

    assert_one_decision_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({dec_f16, dec_f8, dec_f4, dec_none}) == 1));

    assert_width_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((WIDTH_MODE >= 16 || !dec_f16) && (WIDTH_MODE >= 8 || !dec_f8)));

    assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_empty_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    assert_stall_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable({dec_f16, dec_f8, dec_f4, dec_none, dec_hev})));

    assert_drain_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

bind dbk_edge_decide dbk_edge_decide_chk #(.WIDTH_MODE(WIDTH_MODE)) u_chk (.*);

// File: tb/dbk_edge_decide_tb.sv
`timescale 1ns/1ps
module dbk_edge_decide_tb;

    localparam int SW = 12;
    localparam int NT = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst_n;
    logic             in_valid, out_ready, depth_hi;
    logic [NT*SW-1:0] p_taps, q_taps;
    logic [7:0]       thr_e, thr_i, thr_h;
    logic             rdy16, rdy8, rdy4, ov16, ov8, ov4;
    logic [4:0]       d16, d8, d4;

    dbk_edge_decide #(.WIDTH_MODE(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy16),
        .p_taps(p_taps), .q_taps(q_taps), .thr_e(thr_e), .thr_i(thr_i), .thr_h(thr_h),
        .depth_hi(depth_hi), .out_valid(ov16), .out_ready(out_ready),
        .dec_f16(d16[4]), .dec_f8(d16[3]), .dec_f4(d16[2]), .dec_none(d16[1]), .dec_hev(d16[0]));

    dbk_edge_decide #(.WIDTH_MODE(8)) u_dut_w8 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy8),
        .p_taps(p_taps), .q_taps(q_taps), .thr_e(thr_e), .thr_i(thr_i), .thr_h(thr_h),
        .depth_hi(depth_hi), .out_valid(ov8), .out_ready(out_ready),
        .dec_f16(d8[4]), .dec_f8(d8[3]), .dec_f4(d8[2]), .dec_none(d8[1]), .dec_hev(d8[0]));

    dbk_edge_decide #(.WIDTH_MODE(4)) u_dut_w4 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy4),
        .p_taps(p_taps), .q_taps(q_taps), .thr_e(thr_e), .thr_i(thr_i), .thr_h(thr_h),
        .depth_hi(depth_hi), .out_valid(ov4), .out_ready(out_ready),
        .dec_f16(d4[4]), .dec_f8(d4[3]), .dec_f4(d4[2]), .dec_none(d4[1]), .dec_hev(d4[0]));

    int          tp[NT];
    int          tq[NT];
    int          te, ti, th;
    bit          td12;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;
    logic [31:0] rng      = 32'h1234_5678;

    function automatic int unsigned nxt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference decision {f16, f8, f4, none, hev} from the requirements
    function automatic logic [4:0] model(input int mode);
        int sh, msk, es, is_, hs, fs;
        int ps[NT];
        int qs[NT];
        bit fm, fin, fout, hv;
        sh  = td12 ? 4 : 2;
        msk = td12 ? 4095 : 1023;
        es  = te << sh;
        is_ = ti << sh;
        hs  = th << sh;
        fs  = 1 << sh;
        for (int k = 0; k < NT; k++) begin
            ps[k] = tp[k] & msk;
            qs[k] = tq[k] & msk;
        end
        fm = 1'b1;
        for (int k = 1; k < 4; k++) begin
            if (iabs(ps[k] - ps[k-1]) > is_) fm = 1'b0;
            if (iabs(qs[k] - qs[k-1]) > is_) fm = 1'b0;
        end
        if (iabs(qs[0] - ps[0]) * 2 + iabs(qs[1] - ps[1]) / 2 > es) fm = 1'b0;
        hv   = (iabs(ps[1] - ps[0]) > hs) || (iabs(qs[1] - qs[0]) > hs);
        fin  = 1'b1;
        fout = 1'b1;
        for (int k = 1; k < NT; k++) begin
            if (iabs(ps[k] - ps[0]) > fs || iabs(qs[k] - qs[0]) > fs) begin
                if (k < 4) fin = 1'b0;
                else       fout = 1'b0;
            end
        end
        if (mode < 16) fout = 1'b0;
        if (mode < 8)  fin  = 1'b0;
        return {fm & fin & fout, fm & fin & ~fout, fm & ~fin, ~fm, hv};
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic drive();
        for (int k = 0; k < NT; k++) begin
            p_taps[k*SW +: SW] = SW'(tp[k]);
            q_taps[k*SW +: SW] = SW'(tq[k]);
        end
        thr_e    = 8'(te);
        thr_i    = 8'(ti);
        thr_h    = 8'(th);
        depth_hi = td12;
        in_valid = 1'b1;
    endtask

    task automatic set_flat(input int base);
        for (int k = 0; k < NT; k++) begin
            tp[k] = base;
            tq[k] = base;
        end
    endtask

    // Called just after a falling edge; result is checked at the next falling edge
    task automatic run_vec(input string tag);
        logic [4:0] e16, e8, e4;
        drive();
        e16 = model(16);
        e8  = model(8);
        e4  = model(4);
        @(negedge clk);
        check("R9", "out_valid", int'(ov16 & ov8 & ov4), 1);
        check(tag,  "decision w16", int'(d16[4:1]), int'(e16[4:1]));
        check("R4", "hev", int'(d16[0]), int'(e16[0]));
        check("R8", "decision w8", int'(d8[4:1]), int'(e8[4:1]));
        check("R8", "decision w4", int'(d4[4:1]), int'(e4[4:1]));
    endtask

    task automatic rand_vec(input bit junk);
        int f, mx, base, spread, sel;
        f      = td12 ? 16 : 4;
        mx     = td12 ? 4095 : 1023;
        base   = 4 * f + int'(nxt() % (mx - 8 * f));
        sel    = int'(nxt() % 3);
        spread = (sel == 0) ? f : ((sel == 1) ? 2 * f : 4 * f);
        for (int k = 0; k < NT; k++) begin
            tp[k] = base + int'(nxt() % (2 * spread + 1)) - spread;
            tq[k] = base + int'(nxt() % (2 * spread + 1)) - spread;
            if (junk) begin
                tp[k] = tp[k] | (int'(nxt() % 4) << 10);
                tq[k] = tq[k] | (int'(nxt() % 4) << 10);
            end
        end
        te = int'(nxt() % 64);
        ti = int'(nxt() % 16);
        th = int'(nxt() % 8);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [4:0] ea, eb;
        int base, f, sh;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        out_ready = 1'b1;
        depth_hi  = 1'b0;
        p_taps    = '0;
        q_taps    = '0;
        thr_e     = '0;
        thr_i     = '0;
        thr_h     = '0;
        te = 0; ti = 0; th = 0; td12 = 1'b0;
        set_flat(0);
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "out_valid in reset", int'(ov16), 0);
        check("R9", "in_ready in reset",  int'(rdy16), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "out_valid after reset", int'(ov16), 0);

        // Flatness boundaries on every tap, both depths
        for (int d = 0; d < 2; d++) begin
            td12 = d[0];
            te = 255; ti = 255; th = 255;
            base = d ? 2000 : 400;
            f    = d ? 16 : 4;
            for (int side = 0; side < 2; side++) begin
                for (int k = 0; k < NT; k++) begin
                    for (int x = 0; x < 2; x++) begin
                        set_flat(base);
                        if (side == 1) tq[k] += f + x;
                        else           tp[k] += f + x;
                        run_vec((k == 0) ? "R7" : ((k < 4) ? "R5" : "R6"));
                    end
                end
            end
        end

        // Neighbour-step threshold I at its scaled limit (R1, R3)
        for (int d = 0; d < 2; d++) begin
            td12 = d[0];
            sh   = d ? 4 : 2;
            base = d ? 2000 : 400;
            te = 255; th = 255;
            foreach (ea[j]) begin end
            for (int s = 0; s < 3; s++) begin
                ti = (s == 0) ? 3 : ((s == 1) ? 10 : 40);
                for (int x = 0; x < 2; x++) begin
                    set_flat(base);
                    tp[2] += (ti << sh) + x;
                    run_vec("R1");
                    set_flat(base);
                    tq[3] += (ti << sh) + x;
                    run_vec("R3");
                end
            end
            // Edge-step threshold E at its scaled limit
            ti = 255;
            for (int s = 0; s < 3; s++) begin
                te = (s == 0) ? 5 : ((s == 1) ? 20 : 60);
                for (int x = 0; x < 2; x++) begin
                    set_flat(base);
                    tq[0] += ((te << sh) / 2) + x;
                    run_vec("R3");
                end
            end
            // Activity threshold H at its scaled limit
            te = 255;
            for (int s = 0; s < 2; s++) begin
                th = (s == 0) ? 2 : 9;
                for (int x = 0; x < 2; x++) begin
                    set_flat(base);
                    tp[1] += (th << sh) + x;
                    run_vec("R4");
                    set_flat(base);
                    tq[1] -= (th << sh) + x;
                    run_vec("R4");
                end
            end
        end

        // 10-bit mode with junk in the upper bits
        td12 = 1'b0;
        for (int n = 0; n < 150; n++) begin
            rand_vec(1'b1);
            run_vec("R2");
        end

        // Mixed random columns
        for (int n = 0; n < 400; n++) begin
            td12 = n[0];
            rand_vec(1'b0);
            run_vec("R7");
        end

        // Backpressure sequence
        td12 = 1'b1; te = 255; ti = 255; th = 255;
        set_flat(1500);
        drive();
        ea = model(16);
        @(negedge clk);
        check("R9", "stage A decision", int'(d16[4:1]), int'(ea[4:1]));
        out_ready = 1'b0;
        set_flat(1500);
        tp[5] += 17;
        drive();
        eb = model(16);
        #1;
        check("R10", "in_ready while stalled", int'(rdy16), 0);
        @(negedge clk);
        check("R10", "held valid", int'(ov16), 1);
        check("R10", "held decision", int'(d16[4:1]), int'(ea[4:1]));
        @(negedge clk);
        check("R10", "held decision again", int'(d16[4:1]), int'(ea[4:1]));
        check("R10", "in_ready still low", int'(rdy16), 0);
        out_ready = 1'b1;
        @(negedge clk);
        check("R10", "released decision", int'(d16[4:1]), int'(eb[4:1]));
        in_valid = 1'b0;
        @(negedge clk);
        check("R11", "drained valid", int'(ov16), 0);
        // Empty stage with consumer stalled still accepts
        out_ready = 1'b0;
        #1;
        check("R9", "ready when empty", int'(rdy16), 1);
        in_valid = 1'b1;
        @(negedge clk);
        check("R9", "valid after load", int'(ov16), 1);
        check("R9", "loaded decision", int'(d16[4:1]), int'(eb[4:1]));
        in_valid  = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check("R11", "empty again", int'(ov16), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule